// File: doc/BRIEF.md
# Infrared Pulse-Distance Receiver

This block decodes a pulse-distance infrared remote control stream. Its input is the demodulated line, active low and already synchronized to the clock, so a low level means carrier is present. All widths are measured in ticks of a sample-rate strobe. A frame normally opens with a leader: a low pulse and then a high pulse, each of which must fall inside a programmed window. In leader-less mode the first falling edge is taken as the start of data.

Each data bit is decided from the spacing between two consecutive falling edges. Bits are shifted into a buffer of up to 72 bits that is built from three words. A frame ends in one of two ways: no new falling edge arrives within a cycle limit, or the line stays low too long after a falling edge. The first of the two to fire ends the frame. On completion the buffer, the bit count and the cause are published and the receiver goes back to hunting for a leader. A newer frame replaces an unread older one.

Thresholds and enables are static inputs. A host reads the published results and takes one-cycle interrupt pulses for leader detection, data falling edges and completion.

Top module: `ir_rx`

## Requirements
- R1: After reset every output is zero: buffer, bit count, flags, busy and all interrupt pulses.
- R2: A leader is accepted when the low width and then the high width, counted in ticks from edge to edge, each lie within their inclusive min/max window. Acceptance happens on the falling edge that ends the high pulse. It sets `leader_seen`, which `en` low clears. `irq_leader` pulses one cycle later only when `ldr_ie` is 1.
- R3: A leader whose low or high width falls outside its window is rejected. No data is captured from it, and no completion can follow it.
- R4: The tick count between two consecutive data falling edges gives the bit: 1 if the count is at least `bit_thr`, otherwise 0. The newest bit enters `rx_buf[0]` and earlier bits move one place up, so the first bit received ends up in the highest occupied position.
- R5: `rx_bits` reports the number of bits received, from 0 to 72. Bits beyond the 72nd are dropped, and the first 72 stay in the buffer.
- R6: With `cyc_end_en` set, a frame completes when `cyc_end_thr` ticks have passed since the last data falling edge with no new falling edge. `end_by_cyc` then reports 1.
- R7: With `low_end_en` set, a frame completes when the line is still low `low_end_thr` ticks after a data falling edge. `end_by_low` then reports 1. If both limits are reached in the same cycle, both flags are set.
- R8: On completion `rx_buf` and `rx_bits` are loaded and `frame_done` is set. `frame_done` clears when the next frame starts. `irq_done` pulses for exactly one cycle, and the receiver returns to hunting for a leader.
- R9: With `fall_ie` set, `irq_fall` pulses one cycle after every data falling edge. This includes the edge that starts the data, whether that edge ends a leader or opens a leader-less frame.
- R10: With `leaderless` set, the first falling edge starts the data at once and no leader window applies.
- R11: While `en` is 0 no reception takes place, `busy` is 0 and published results keep their values.
- R12: A second completed frame overwrites the published buffer, count and cause without any read in between.
- R13: Width counters advance only on cycles where `tick` is 1, so every threshold is measured in ticks and not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_n | input | 1 | Synchronized demodulated line, low while carrier is present |
| tick | input | 1 | Sample-rate strobe that advances the width counters |
| en | input | 1 | Arms reception |
| leaderless | input | 1 | Start on the first falling edge without a leader |
| ldr_ie | input | 1 | Enables the leader interrupt pulse |
| fall_ie | input | 1 | Enables the data falling-edge interrupt pulse |
| cyc_end_en | input | 1 | Enables completion by the bit-cycle limit |
| low_end_en | input | 1 | Enables completion by the low-width limit |
| lead_lo_min | input | CNT_W | Minimum leader low width, ticks |
| lead_lo_max | input | CNT_W | Maximum leader low width, ticks |
| lead_hi_min | input | CNT_W | Minimum leader high width, ticks |
| lead_hi_max | input | CNT_W | Maximum leader high width, ticks |
| bit_thr | input | CNT_W | Period at or above which a bit is 1, ticks |
| cyc_end_thr | input | CNT_W | Bit-cycle completion limit, ticks |
| low_end_thr | input | CNT_W | Low-width completion limit, ticks |
| rx_buf | output | MAX_BITS | Published received bits, newest at bit 0 |
| rx_bits | output | BCW | Published bit count |
| leader_seen | output | 1 | Leader detected since enable |
| frame_done | output | 1 | A completed frame is published |
| end_by_cyc | output | 1 | Last completion came from the bit-cycle limit |
| end_by_low | output | 1 | Last completion came from the low-width limit |
| busy | output | 1 | Receiver is not hunting for a leader |
| irq_leader | output | 1 | One-cycle leader interrupt |
| irq_fall | output | 1 | One-cycle data falling-edge interrupt |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
A line change sampled at a clock edge is judged at that same edge. `irq_leader`, `irq_fall` and `irq_done`, together with the published buffer, count, flags and `busy`, all appear one cycle later, since each sits behind one register. A limit fires at the edge where the tick count since the last falling edge first reaches the threshold, and the completion pulse follows one cycle after that. The bench keeps a behavioural reference that advances at each rising edge and compares every output one time unit after that edge. Packed buffer contents and pulse totals are checked separately, computed from the bit patterns that were sent.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_LEAD_LO = 2'd1,
    ST_LEAD_HI = 2'd2,
    ST_DATA    = 2'd3
  } rx_state_e;

  // inclusive window test on tick counts
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // bit decision from a falling-edge to falling-edge period
  function automatic logic bit_value(input int unsigned period,
                                     input int unsigned thr);
    return period >= thr;
  endfunction

  // limit reached test used by both completion detectors
  function automatic logic limit_hit(input logic armed,
                                     input int unsigned cnt,
                                     input int unsigned thr);
    return armed && (cnt >= thr);
  endfunction

endpackage

// File: rtl/ir_rx_edge.sv
module ir_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_n;
  end

  assign fall = prev_q & ~rx_n;
  assign rise = ~prev_q & rx_n;
endmodule

// File: rtl/ir_rx_timer.sv
module ir_rx_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic t);
    if (t && (c != CNT_MAX)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (zero)    cnt <= '0;
    else if (restart) cnt <= CNT_W'(tick);
    else              cnt <= step(cnt, tick);
  end
endmodule

// File: rtl/ir_rx_shift.sv
module ir_rx_shift #(
  parameter int MAX_BITS = 72,
  parameter int WORD_W   = 24,
  localparam int NWORDS  = (MAX_BITS + WORD_W - 1) / WORD_W,
  localparam int TOT_W   = NWORDS * WORD_W,
  localparam int BCW     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  logic                bit_in,
  output logic [MAX_BITS-1:0] data,
  output logic [BCW-1:0]      count
);
  localparam logic [BCW-1:0] FULL = BCW'(MAX_BITS);

  logic [WORD_W-1:0] word_q [NWORDS];
  logic [NWORDS-1:0] carry;
  logic [TOT_W-1:0]  flat;
  logic              accept;

  assign accept   = push && (count != FULL);
  assign carry[0] = bit_in;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    if (w < NWORDS - 1) begin : g_link
      assign carry[w+1] = word_q[w][WORD_W-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[w] <= '0;
      else if (clear)  word_q[w] <= '0;
      else if (accept) word_q[w] <= {word_q[w][WORD_W-2:0], carry[w]};
    end
    assign flat[w*WORD_W +: WORD_W] = word_q[w];
  end

  assign data = flat[MAX_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (accept) count <= count + 1'b1;
  end
endmodule

// File: rtl/ir_rx.sv
module ir_rx
  import ir_rx_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MAX_BITS = 72,
  parameter int WORD_W   = 24,
  localparam int BCW     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_n,
  input  logic                tick,
  input  logic                en,
  input  logic                leaderless,
  input  logic                ldr_ie,
  input  logic                fall_ie,
  input  logic                cyc_end_en,
  input  logic                low_end_en,
  input  logic [CNT_W-1:0]    lead_lo_min,
  input  logic [CNT_W-1:0]    lead_lo_max,
  input  logic [CNT_W-1:0]    lead_hi_min,
  input  logic [CNT_W-1:0]    lead_hi_max,
  input  logic [CNT_W-1:0]    bit_thr,
  input  logic [CNT_W-1:0]    cyc_end_thr,
  input  logic [CNT_W-1:0]    low_end_thr,
  output logic [MAX_BITS-1:0] rx_buf,
  output logic [BCW-1:0]      rx_bits,
  output logic                leader_seen,
  output logic                frame_done,
  output logic                end_by_cyc,
  output logic                end_by_low,
  output logic                busy,
  output logic                irq_leader,
  output logic                irq_fall,
  output logic                irq_done
);

  rx_state_e state, state_n;

  // named internal events, also observed by the checker
  logic ev_fall, ev_rise;
  logic ev_end_cyc, ev_end_low, ev_complete;
  logic lead_accept, frame_start, sh_push;
  logic tmr_zero, tmr_restart;
  logic lo_ok, hi_ok, lo_over, hi_over;
  logic still_low;
  logic [CNT_W-1:0]    cnt;
  logic [MAX_BITS-1:0] sh_data;
  logic [BCW-1:0]      sh_count;
  logic                sh_bit;

  ir_rx_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .rx_n (rx_n),
    .fall (ev_fall),
    .rise (ev_rise)
  );

  ir_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .zero   (tmr_zero),
    .restart(tmr_restart),
    .tick   (tick),
    .cnt    (cnt)
  );

  ir_rx_shift #(.MAX_BITS(MAX_BITS), .WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frame_start),
    .push  (sh_push),
    .bit_in(sh_bit),
    .data  (sh_data),
    .count (sh_count)
  );

  assign lo_ok   = in_window(32'(cnt), 32'(lead_lo_min), 32'(lead_lo_max));
  assign hi_ok   = in_window(32'(cnt), 32'(lead_hi_min), 32'(lead_hi_max));
  assign lo_over = cnt > lead_lo_max;
  assign hi_over = cnt > lead_hi_max;
  assign sh_bit  = bit_value(32'(cnt), 32'(bit_thr));

  assign ev_end_cyc = en && (state == ST_DATA) &&
                      limit_hit(cyc_end_en, 32'(cnt), 32'(cyc_end_thr));
  assign ev_end_low = en && (state == ST_DATA) &&
                      limit_hit(low_end_en && still_low, 32'(cnt), 32'(low_end_thr));
  assign ev_complete = ev_end_cyc || ev_end_low;

  always_comb begin
    state_n     = state;
    tmr_zero    = 1'b0;
    tmr_restart = 1'b0;
    frame_start = 1'b0;
    lead_accept = 1'b0;
    sh_push     = 1'b0;
    if (!en) begin
      state_n  = ST_HUNT;
      tmr_zero = 1'b1;
    end else begin
      unique case (state)
        ST_HUNT: begin
          if (ev_fall) begin
            tmr_restart = 1'b1;
            if (leaderless) begin
              state_n     = ST_DATA;
              frame_start = 1'b1;
            end else begin
              state_n = ST_LEAD_LO;
            end
          end else begin
            tmr_zero = 1'b1;
          end
        end
        ST_LEAD_LO: begin
          if (ev_rise) begin
            if (lo_ok) begin
              state_n     = ST_LEAD_HI;
              tmr_restart = 1'b1;
            end else begin
              state_n  = ST_HUNT;
              tmr_zero = 1'b1;
            end
          end else if (lo_over) begin
            state_n  = ST_HUNT;
            tmr_zero = 1'b1;
          end
        end
        ST_LEAD_HI: begin
          if (ev_fall) begin
            tmr_restart = 1'b1;
            if (hi_ok) begin
              state_n     = ST_DATA;
              frame_start = 1'b1;
              lead_accept = 1'b1;
            end else begin
              state_n = ST_LEAD_LO;
            end
          end else if (hi_over) begin
            state_n  = ST_HUNT;
            tmr_zero = 1'b1;
          end
        end
        ST_DATA: begin
          if (ev_complete) begin
            state_n  = ST_HUNT;
            tmr_zero = 1'b1;
          end else if (ev_fall) begin
            sh_push     = 1'b1;
            tmr_restart = 1'b1;
          end
        end
        default: begin
          state_n  = ST_HUNT;
          tmr_zero = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_HUNT;
    else        state <= state_n;
  end

  // line still low since the last data falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          still_low <= 1'b0;
    else if (!en || ev_complete)         still_low <= 1'b0;
    else if (frame_start || sh_push)     still_low <= 1'b1;
    else if (ev_rise)                    still_low <= 1'b0;
  end

  // interrupt pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_leader <= 1'b0;
      irq_fall   <= 1'b0;
      irq_done   <= 1'b0;
    end else begin
      irq_leader <= lead_accept & ldr_ie;
      irq_fall   <= (frame_start | sh_push) & fall_ie;
      irq_done   <= ev_complete;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leader_seen <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      if (!en)              leader_seen <= 1'b0;
      else if (lead_accept) leader_seen <= 1'b1;
      if (frame_start)      frame_done <= 1'b0;
      else if (ev_complete) frame_done <= 1'b1;
    end
  end

  // published results, overwritten by every completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf     <= '0;
      rx_bits    <= '0;
      end_by_cyc <= 1'b0;
      end_by_low <= 1'b0;
    end else if (ev_complete) begin
      rx_buf     <= sh_data;
      rx_bits    <= sh_count;
      end_by_cyc <= ev_end_cyc;
      end_by_low <= ev_end_low;
    end
  end

  assign busy = (state != ST_HUNT);

endmodule

// File: rtl/ir_rx_chk.sv
module ir_rx_chk #(
  parameter int MAX_BITS = 72,
  parameter int BCW      = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           ldr_ie,
  input logic           fall_ie,
  input logic           sh_push,
  input logic           lead_accept,
  input logic           busy,
  input logic           irq_leader,
  input logic           irq_fall,
  input logic           irq_done,
  input logic           leader_seen,
  input logic           frame_done,
  input logic           end_by_cyc,
  input logic           end_by_low,
  input logic [BCW-1:0] rx_bits
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> frame_done);

  assert_cause_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (end_by_cyc || end_by_low));

  assert_bits_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bits <= BCW'(MAX_BITS));

  assert_fall_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_push && fall_ie) |=> irq_fall);

  assert_leader_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_accept && !ldr_ie) |=> !irq_leader);

  assert_leader_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_leader |-> leader_seen);

  assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind ir_rx ir_rx_chk #(.MAX_BITS(MAX_BITS), .BCW(BCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ldr_ie     (ldr_ie),
  .fall_ie    (fall_ie),
  .sh_push    (sh_push),
  .lead_accept(lead_accept),
  .busy       (busy),
  .irq_leader (irq_leader),
  .irq_fall   (irq_fall),
  .irq_done   (irq_done),
  .leader_seen(leader_seen),
  .frame_done (frame_done),
  .end_by_cyc (end_by_cyc),
  .end_by_low (end_by_low),
  .rx_bits    (rx_bits)
);

// File: tb/ir_rx_tb.sv
module ir_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int MAXB  = 72;
  localparam int BCW   = 7;
  localparam int CMAX  = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_n = 1'b1, tick = 1'b1, en = 1'b0, leaderless = 1'b0;
  logic ldr_ie = 1'b1, fall_ie = 1'b1, cyc_end_en = 1'b1, low_end_en = 1'b1;
  logic [CNT_W-1:0] lead_lo_min = 10'd8, lead_lo_max = 10'd12;
  logic [CNT_W-1:0] lead_hi_min = 10'd4, lead_hi_max = 10'd6;
  logic [CNT_W-1:0] bit_thr = 10'd5, cyc_end_thr = 10'd10, low_end_thr = 10'd8;
  logic [MAXB-1:0] rx_buf;
  logic [BCW-1:0]  rx_bits;
  logic leader_seen, frame_done, end_by_cyc, end_by_low, busy;
  logic irq_leader, irq_fall, irq_done;

  int n_checks = 0, n_fail = 0;
  bit half_tick = 0;
  bit finished = 0;
  int cnt_ldr = 0, cnt_fall = 0, cnt_done = 0;
  int pat[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_n(rx_n), .tick(tick), .en(en),
    .leaderless(leaderless), .ldr_ie(ldr_ie), .fall_ie(fall_ie),
    .cyc_end_en(cyc_end_en), .low_end_en(low_end_en),
    .lead_lo_min(lead_lo_min), .lead_lo_max(lead_lo_max),
    .lead_hi_min(lead_hi_min), .lead_hi_max(lead_hi_max),
    .bit_thr(bit_thr), .cyc_end_thr(cyc_end_thr), .low_end_thr(low_end_thr),
    .rx_buf(rx_buf), .rx_bits(rx_bits), .leader_seen(leader_seen),
    .frame_done(frame_done), .end_by_cyc(end_by_cyc), .end_by_low(end_by_low),
    .busy(busy), .irq_leader(irq_leader), .irq_fall(irq_fall), .irq_done(irq_done)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  m_phase, m_cnt;
  bit  m_prev, m_low;
  bit  e_ldr_seen, e_done, e_cyc, e_low, e_il, e_if, e_id;
  bit  m_q[$];
  logic [MAXB-1:0] e_buf;
  int  e_bits;

  function automatic logic [MAXB-1:0] pack_bits(input bit q[$]);
    logic [MAXB-1:0] v = '0;
    foreach (q[i]) if (i < MAXB) v[q.size() > MAXB ? MAXB-1-i : q.size()-1-i] = q[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_prev = 1; m_low = 0;
      e_ldr_seen = 0; e_done = 0; e_cyc = 0; e_low = 0;
      e_il = 0; e_if = 0; e_id = 0; e_buf = '0; e_bits = 0; m_q.delete();
    end else begin
      bit f, r, start, ec, el;
      int nc;
      f = m_prev && !rx_n;
      r = !m_prev && rx_n;
      m_prev = rx_n;
      e_il = 0; e_if = 0; e_id = 0; start = 0;
      nc = (m_cnt + int'(tick) > CMAX) ? CMAX : m_cnt + int'(tick);
      if (!en) begin
        m_phase = 0; m_cnt = 0; m_low = 0; e_ldr_seen = 0;
      end else begin
        case (m_phase)
          0: begin
            m_cnt = 0;
            if (f) begin
              m_cnt = int'(tick);
              if (leaderless) start = 1; else m_phase = 1;
            end
          end
          1: begin
            if (r) begin
              if (m_cnt >= lead_lo_min && m_cnt <= lead_lo_max) begin m_phase = 2; m_cnt = int'(tick); end
              else begin m_phase = 0; m_cnt = 0; end
            end else if (m_cnt > lead_lo_max) begin m_phase = 0; m_cnt = 0; end
            else m_cnt = nc;
          end
          2: begin
            if (f) begin
              if (m_cnt >= lead_hi_min && m_cnt <= lead_hi_max) begin
                start = 1; e_ldr_seen = 1; e_il = ldr_ie;
              end else m_phase = 1;
              m_cnt = int'(tick);
            end else if (m_cnt > lead_hi_max) begin m_phase = 0; m_cnt = 0; end
            else m_cnt = nc;
          end
          default: begin
            ec = cyc_end_en && m_cnt >= cyc_end_thr;
            el = low_end_en && m_low && m_cnt >= low_end_thr;
            if (ec || el) begin
              e_buf = pack_bits(m_q); e_bits = m_q.size();
              e_done = 1; e_id = 1; e_cyc = ec; e_low = el;
              m_phase = 0; m_cnt = 0; m_low = 0;
            end else if (f) begin
              if (m_q.size() < MAXB) m_q.push_back(m_cnt >= bit_thr);
              m_low = 1; m_cnt = int'(tick); e_if = fall_ie;
            end else begin
              if (r) m_low = 0;
              m_cnt = nc;
            end
          end
        endcase
        if (start) begin
          m_phase = 3; m_q.delete(); m_low = 1; e_done = 0; e_if = fall_ie;
        end
      end
    end
  end

  // compare every cycle, one time unit after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (irq_leader) cnt_ldr++;
      if (irq_fall)   cnt_fall++;
      if (irq_done)   cnt_done++;
      check("R2 irq_leader", irq_leader, e_il);
      check("R2 leader_seen", leader_seen, e_ldr_seen);
      check("R9 irq_fall", irq_fall, e_if);
      check("R8 irq_done", irq_done, e_id);
      check("R8 frame_done", frame_done, e_done);
      check("R4 rx_buf", rx_buf, e_buf);
      check("R5 rx_bits", rx_bits, e_bits);
      check("R6 end_by_cyc", end_by_cyc, e_cyc);
      check("R7 end_by_low", end_by_low, e_low);
      check("R11 busy", busy, m_phase != 0);
    end
  end

  always @(negedge clk) tick = half_tick ? ~tick : 1'b1;

  // ---------------- stimulus ----------------
  task automatic hold(input logic v, input int n);
    rx_n = v;
    repeat (n) @(negedge clk);
  endtask

  // one frame from the pattern queue; s scales cycles for the tick rate
  task automatic send(input bit lead, input bit lowend, input int s);
    if (lead) begin hold(0, 10*s); hold(1, 5*s); end
    foreach (pat[i]) begin
      hold(0, 1*s);
      hold(1, (pat[i] ? 6 : 3)*s - s);
    end
    if (lowend) begin hold(0, 12*s); hold(1, 6*s); end
    else begin hold(0, 1*s); hold(1, 16*s); end
  endtask

  function automatic logic [MAXB-1:0] expect_buf();
    logic [MAXB-1:0] v = '0;
    foreach (pat[i]) if (i < MAXB) v = {v[MAXB-2:0], pat[i][0]};
    return v;
  endfunction

  function automatic int expect_bits();
    return pat.size() > MAXB ? MAXB : pat.size();
  endfunction

  task automatic load(input logic [31:0] v, input int n);
    pat.delete();
    for (int i = n-1; i >= 0; i--) pat.push_back(int'(v[i]));
  endtask

  initial begin
    logic [MAXB-1:0] keep;
    int f0, d0, l0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rx_buf", rx_buf, '0);
    check("R1 rx_bits", rx_bits, 0);
    check("R1 flags", {leader_seen, frame_done, end_by_cyc, end_by_low, busy}, 5'd0);
    check("R1 irqs", {irq_leader, irq_fall, irq_done}, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R6 R8 R9: leader frame ending on the bit-cycle limit
    load(32'hB38D, 16);
    f0 = cnt_fall; l0 = cnt_ldr; d0 = cnt_done;
    send(1, 0, 1);
    check("R4 frame1 buffer", rx_buf, expect_buf());
    check("R5 frame1 count", rx_bits, expect_bits());
    check("R6 frame1 cause", {end_by_cyc, end_by_low}, 2'b10);
    check("R8 frame1 done", frame_done, 1);
    check("R9 frame1 falls", cnt_fall - f0, pat.size() + 1);
    check("R2 frame1 leader irq", cnt_ldr - l0, 1);
    check("R8 frame1 done pulses", cnt_done - d0, 1);
    check("R8 back to hunting", busy, 0);

    // R7 R12: overwrite with a frame ending on low width, leader irq off
    ldr_ie = 1'b0;
    load(32'h5A, 8);
    l0 = cnt_ldr;
    send(1, 1, 1);
    check("R12 overwrite buffer", rx_buf, expect_buf());
    check("R12 overwrite count", rx_bits, 8);
    check("R7 low cause", {end_by_cyc, end_by_low}, 2'b01);
    check("R2 leader irq gated", cnt_ldr - l0, 0);
    check("R2 leader flag", leader_seen, 1);

    // R3: leader low too long, then high too short: rejected
    keep = rx_buf; d0 = cnt_done;
    hold(0, 20); hold(1, 5); load(32'h3, 2);
    foreach (pat[i]) begin hold(0, 1); hold(1, 5); end
    hold(1, 20);
    hold(0, 10); hold(1, 2); hold(0, 1); hold(1, 20);
    check("R3 no completion", cnt_done - d0, 0);
    check("R3 buffer kept", rx_buf, keep);

    // R5: 75 bits, only the first 72 kept
    ldr_ie = 1'b1;
    pat.delete();
    for (int i = 0; i < 75; i++) pat.push_back((i % 3 == 0) ? 1 : ((i % 7) == 2 ? 1 : 0));
    send(1, 0, 1);
    check("R5 capped count", rx_bits, 72);
    check("R5 first 72 kept", rx_buf, expect_buf());

    // R10: leader-less start, first fall starts data
    leaderless = 1'b1;
    load(32'h2D3, 10);
    f0 = cnt_fall; l0 = cnt_ldr;
    send(0, 0, 1);
    check("R10 leaderless buffer", rx_buf, expect_buf());
    check("R10 leaderless count", rx_bits, 10);
    check("R9 leaderless falls", cnt_fall - f0, 11);
    check("R10 no leader irq", cnt_ldr - l0, 0);
    leaderless = 1'b0;

    // R13: tick every second cycle, durations doubled
    half_tick = 1;
    load(32'hC5A, 12);
    send(1, 0, 2);
    check("R13 half tick buffer", rx_buf, expect_buf());
    check("R13 half tick count", rx_bits, 12);
    half_tick = 0;
    @(negedge clk);

    // R11: disabled receiver ignores a valid frame
    en = 1'b0;
    keep = rx_buf; d0 = cnt_done; f0 = cnt_fall;
    load(32'hF0, 8);
    send(1, 0, 1);
    check("R11 no completion", cnt_done - d0, 0);
    check("R11 no falls", cnt_fall - f0, 0);
    check("R11 buffer kept", rx_buf, keep);
    check("R11 leader flag cleared", leader_seen, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule